// File: doc/BRIEF.md
# DMA Channel Descriptor Register Bank

This block holds the programming state of a multi-channel DMA engine behind a simple memory-mapped request port. Each channel owns a 32-bit control word and a "next" transfer descriptor. The next descriptor has a 32-bit configuration word and three 64-bit fields: byte count, destination address and source address. Each channel also owns a read-only "executing" copy of that descriptor. Software programs the next descriptor. A per-channel start pulse from the data mover latches it into the executing copy, where software can watch it but not alter it.

A request carries a write flag, an address, an access size in bytes and 64 bits of write data. The upper address bits pick the channel and the low twelve bits pick the register inside it. The 64-bit descriptor fields accept a single 64-bit access, or two independent 32-bit accesses to their lower and upper words. Every read gets a response one cycle later. Every access that cannot be served raises a one-cycle error strobe, also one cycle later. The control word is only stored here. Its meaning belongs to the data mover.

Top module: `dmareg_bank`

## Requirements
- R1: After reset every register of every channel reads as zero, and `rsp_valid_o` and `err_o` are low.
- R2: Address bits `[ADDR_W-1:12]` give the channel number and bits `[11:0]` give the offset within that channel. A write to one channel leaves every other channel unchanged.
- R3: An access whose channel number is `NCH` or larger reads 0, changes no register and pulses `err_o`.
- R4: Only access sizes 4 and 8 are valid. Any other `req_size_i` value reads 0, changes no register and pulses `err_o`.
- R5: A 32-bit access at a 64-bit field's base offset reaches bits 31:0. The same access at base+4 reaches bits 63:32. A 32-bit write changes only its own half, and only `req_wdata_i[31:0]` is used.
- R6: A 64-bit access at a 64-bit field's base offset reads or writes all 64 bits at once.
- R7: The executing copies are read-only at every width and half. Writes to them change nothing and do not pulse `err_o`.
- R8: The control word (offset 0x000) and next config (0x004) accept only 32-bit accesses. A 64-bit access to them reads 0, writes nothing and pulses `err_o`, and so does any access to an unmapped offset. The register map is as follows:
  - next byte count at 0x008, next destination at 0x010 and next source at 0x018;
  - executing config at 0x104 and executing byte count at 0x108;
  - executing destination at 0x110 and executing source at 0x118.
- R9: A high `start_i[i]` at a clock edge copies channel i's next config, byte count, destination and source, as held before that edge, into its executing copies.
- R10: A read request gets `rsp_valid_o` high with `rsp_rdata_o` in the next cycle. A 32-bit read returns zero in bits 63:32.
- R11: `err_o` is high for exactly the one cycle after each invalid access and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address: channel in upper bits, offset in low 12 |
| req_size_i | input | 4 | Access size in bytes (4 or 8 valid) |
| req_wdata_i | input | 64 | Write data (low 32 bits for 32-bit writes) |
| start_i | input | NCH | Per-channel latch of next descriptor into executing copy |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 64 | Read data |
| err_o | output | 1 | One-cycle strobe after an invalid access |

## Verification
The assertions take for granted that the request inputs are driven to known values in every cycle while `req_valid_i` is high. They also take for granted that `start_i` is never unknown. They do not assume any limit on address, size or back-to-back requests. The stimulus therefore mixes every mapped offset with random aligned offsets. It also mixes sizes 4 and 8 with illegal sizes, and channel numbers inside and beyond the configured count. Start pulses are placed between accesses so that every latch happens at a known edge.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int OFS_W   = 12;
    localparam int DATA_W  = 64;
    localparam int HALF_W  = 32;

    // Offsets inside a channel window; base+4 is the upper half of a 64-bit field
    localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [OFS_W-1:0] OFS_NCFG   = 12'h004;
    localparam logic [OFS_W-1:0] OFS_NBYTES = 12'h008;
    localparam logic [OFS_W-1:0] OFS_NDST   = 12'h010;
    localparam logic [OFS_W-1:0] OFS_NSRC   = 12'h018;
    localparam logic [OFS_W-1:0] OFS_XCFG   = 12'h104;
    localparam logic [OFS_W-1:0] OFS_XBYTES = 12'h108;
    localparam logic [OFS_W-1:0] OFS_XDST   = 12'h110;
    localparam logic [OFS_W-1:0] OFS_XSRC   = 12'h118;

    typedef enum logic [3:0] {
        FLD_NONE,
        FLD_CTRL,
        FLD_NCFG,
        FLD_NBYTES,
        FLD_NDST,
        FLD_NSRC,
        FLD_XCFG,
        FLD_XBYTES,
        FLD_XDST,
        FLD_XSRC
    } field_e;

    typedef struct packed {
        field_e fld;
        logic   hi;    // 32-bit access to bits 63:32
        logic   wide;  // 64-bit access
        logic   ok;    // offset/size combination is mapped
    } dec_t;

    typedef struct packed {
        logic [HALF_W-1:0] ctrl;
        logic [HALF_W-1:0] ncfg;
        logic [DATA_W-1:0] nbytes;
        logic [DATA_W-1:0] ndst;
        logic [DATA_W-1:0] nsrc;
        logic [HALF_W-1:0] xcfg;
        logic [DATA_W-1:0] xbytes;
        logic [DATA_W-1:0] xdst;
        logic [DATA_W-1:0] xsrc;
    } chan_regs_t;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
(
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [3:0]       size_i,
    output dec_t             dec_o
);

    always_comb begin
        dec_o = '{fld: FLD_NONE, hi: 1'b0, wide: 1'b0, ok: 1'b0};
        if (size_i == 4'd4) begin
            dec_o.ok = 1'b1;
            case (ofs_i)
                OFS_CTRL:          dec_o.fld = FLD_CTRL;
                OFS_NCFG:          dec_o.fld = FLD_NCFG;
                OFS_NBYTES:        dec_o.fld = FLD_NBYTES;
                OFS_NBYTES + 12'd4: begin dec_o.fld = FLD_NBYTES; dec_o.hi = 1'b1; end
                OFS_NDST:          dec_o.fld = FLD_NDST;
                OFS_NDST + 12'd4:  begin dec_o.fld = FLD_NDST;   dec_o.hi = 1'b1; end
                OFS_NSRC:          dec_o.fld = FLD_NSRC;
                OFS_NSRC + 12'd4:  begin dec_o.fld = FLD_NSRC;   dec_o.hi = 1'b1; end
                OFS_XCFG:          dec_o.fld = FLD_XCFG;
                OFS_XBYTES:        dec_o.fld = FLD_XBYTES;
                OFS_XBYTES + 12'd4: begin dec_o.fld = FLD_XBYTES; dec_o.hi = 1'b1; end
                OFS_XDST:          dec_o.fld = FLD_XDST;
                OFS_XDST + 12'd4:  begin dec_o.fld = FLD_XDST;   dec_o.hi = 1'b1; end
                OFS_XSRC:          dec_o.fld = FLD_XSRC;
                OFS_XSRC + 12'd4:  begin dec_o.fld = FLD_XSRC;   dec_o.hi = 1'b1; end
                default:           dec_o.ok  = 1'b0;
            endcase
        end else if (size_i == 4'd8) begin
            dec_o.ok   = 1'b1;
            dec_o.wide = 1'b1;
            case (ofs_i)
                OFS_NBYTES: dec_o.fld = FLD_NBYTES;
                OFS_NDST:   dec_o.fld = FLD_NDST;
                OFS_NSRC:   dec_o.fld = FLD_NSRC;
                OFS_XBYTES: dec_o.fld = FLD_XBYTES;
                OFS_XDST:   dec_o.fld = FLD_XDST;
                OFS_XSRC:   dec_o.fld = FLD_XSRC;
                default: begin
                    dec_o.ok   = 1'b0;
                    dec_o.wide = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  dec_t              dec_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              start_i,
    output logic [DATA_W-1:0] rdata_o
);

    chan_regs_t regs_d, regs_q;

    function automatic logic [DATA_W-1:0] merge64(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] wd,
                                                  input dec_t            dc);
        if (dc.wide)    return wd;
        else if (dc.hi) return {wd[HALF_W-1:0], old[HALF_W-1:0]};
        else            return {old[DATA_W-1:HALF_W], wd[HALF_W-1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] pick64(input logic [DATA_W-1:0] v,
                                                 input dec_t            dc);
        if (dc.wide)    return v;
        else if (dc.hi) return {{HALF_W{1'b0}}, v[DATA_W-1:HALF_W]};
        else            return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (start_i) begin
            regs_d.xcfg   = regs_q.ncfg;
            regs_d.xbytes = regs_q.nbytes;
            regs_d.xdst   = regs_q.ndst;
            regs_d.xsrc   = regs_q.nsrc;
        end
        if (wr_en_i && dec_i.ok) begin
            case (dec_i.fld)
                FLD_CTRL:   regs_d.ctrl   = wdata_i[HALF_W-1:0];
                FLD_NCFG:   regs_d.ncfg   = wdata_i[HALF_W-1:0];
                FLD_NBYTES: regs_d.nbytes = merge64(regs_q.nbytes, wdata_i, dec_i);
                FLD_NDST:   regs_d.ndst   = merge64(regs_q.ndst, wdata_i, dec_i);
                FLD_NSRC:   regs_d.nsrc   = merge64(regs_q.nsrc, wdata_i, dec_i);
                default:    ; // executing copies are read-only
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (dec_i.fld)
            FLD_CTRL:   rdata_o = {{HALF_W{1'b0}}, regs_q.ctrl};
            FLD_NCFG:   rdata_o = {{HALF_W{1'b0}}, regs_q.ncfg};
            FLD_NBYTES: rdata_o = pick64(regs_q.nbytes, dec_i);
            FLD_NDST:   rdata_o = pick64(regs_q.ndst, dec_i);
            FLD_NSRC:   rdata_o = pick64(regs_q.nsrc, dec_i);
            FLD_XCFG:   rdata_o = {{HALF_W{1'b0}}, regs_q.xcfg};
            FLD_XBYTES: rdata_o = pick64(regs_q.xbytes, dec_i);
            FLD_XDST:   rdata_o = pick64(regs_q.xdst, dec_i);
            FLD_XSRC:   rdata_o = pick64(regs_q.xsrc, dec_i);
            default:    rdata_o = '0;
        endcase
    end

    // R7: executing copies move only on a start pulse
    p_exec_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(regs_q.xcfg) && $stable(regs_q.xbytes) &&
                      $stable(regs_q.xdst) && $stable(regs_q.xsrc)));

    // R9: start latches the next descriptor as it stood before the edge
    p_start_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (regs_q.xbytes == $past(regs_q.nbytes) &&
                     regs_q.xdst == $past(regs_q.ndst) &&
                     regs_q.xsrc == $past(regs_q.nsrc) &&
                     regs_q.xcfg == $past(regs_q.ncfg)));

    // R2: without a write enable the programmable registers hold
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(regs_q.ctrl) && $stable(regs_q.ncfg) &&
                      $stable(regs_q.nbytes) && $stable(regs_q.ndst) &&
                      $stable(regs_q.nsrc)));

endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
    import dmareg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [3:0]        req_size_i,
    input  logic [63:0]       req_wdata_i,
    input  logic [NCH-1:0]    start_i,
    output logic              rsp_valid_o,
    output logic [63:0]       rsp_rdata_o,
    output logic              err_o
);

    localparam int CH_AW = ADDR_W - OFS_W;
    localparam logic [CH_AW:0] NCH_L = (CH_AW+1)'(NCH);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [CH_AW-1:0]  ch_num;
    logic [OFS_W-1:0]  ofs;
    logic              ch_ok;
    logic              acc_ok;
    dec_t              dec;
    logic [DATA_W-1:0] chan_rd [NCH];
    logic [DATA_W-1:0] rd_sel;

    assign ch_num = req_addr_i[ADDR_W-1:OFS_W];
    assign ofs    = req_addr_i[OFS_W-1:0];
    assign ch_ok  = ({1'b0, ch_num} < NCH_L);
    assign acc_ok = dec.ok && ch_ok;

    dmareg_decode u_dec (
        .ofs_i  (ofs),
        .size_i (req_size_i),
        .dec_o  (dec)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        logic wr_en;
        assign wr_en = req_valid_i && req_write_i && acc_ok &&
                       (ch_num == CH_AW'(gi));
        dmareg_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (wr_en),
            .dec_i   (dec),
            .wdata_i (req_wdata_i),
            .start_i (start_i[gi]),
            .rdata_o (chan_rd[gi])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_num == CH_AW'(i)) rd_sel = chan_rd[i];
        end
    end

    always_comb begin
        rsp_d.valid = req_valid_i && !req_write_i;
        rsp_d.rdata = (req_valid_i && !req_write_i && acc_ok) ? rd_sel : '0;
        rsp_d.err   = req_valid_i && !acc_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_rdata_o = rsp_q.rdata;
    assign err_o       = rsp_q.err;

    // R10: every read request is answered in the next cycle
    p_rsp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);

    // R10: narrow reads carry nothing in the upper word
    p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && req_size_i == 4'd4) |=>
            (rsp_rdata_o[63:32] == 32'h0));

    // R11: the error strobe only follows a request
    p_err_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_valid_i));

    // R3: out-of-range channel is flagged and reads as zero
    p_bad_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !ch_ok) |=> (err_o && rsp_rdata_o == '0));

    // R4: illegal sizes are flagged
    p_bad_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i != 4'd4 && req_size_i != 4'd8) |=> err_o);

    // R8: 64-bit access to a 32-bit-only word is flagged
    p_wide_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i == 4'd8 &&
         (ofs == OFS_CTRL || ofs == OFS_NCFG)) |=> err_o);

endmodule

// File: tb/dmareg_bank_tb.sv
`timescale 1ns/1ps
module dmareg_bank_tb_top;

    localparam int NCH    = 4;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = 4'd4;
    logic [63:0]       req_wdata = '0;
    logic [NCH-1:0]    start = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              err;

    int checks = 0;
    int errors = 0;

    // model: 0 ctrl,1 ncfg,2 nbytes,3 ndst,4 nsrc,5 xcfg,6 xbytes,7 xdst,8 xsrc
    logic [63:0] mdl [NCH][9];

    always #2.5 clk = ~clk;

    dmareg_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_size_i  (req_size),
        .req_wdata_i (req_wdata),
        .start_i     (start),
        .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata),
        .err_o       (err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void mdl_dec(input logic [11:0] ofs, input logic [3:0] sz,
                                    output int idx, output bit hi, output bit wide);
        idx = -1; hi = 0; wide = 0;
        if (sz == 4) begin
            case (ofs)
                12'h000: idx = 0;
                12'h004: idx = 1;
                12'h008: idx = 2;  12'h00C: begin idx = 2; hi = 1; end
                12'h010: idx = 3;  12'h014: begin idx = 3; hi = 1; end
                12'h018: idx = 4;  12'h01C: begin idx = 4; hi = 1; end
                12'h104: idx = 5;
                12'h108: idx = 6;  12'h10C: begin idx = 6; hi = 1; end
                12'h110: idx = 7;  12'h114: begin idx = 7; hi = 1; end
                12'h118: idx = 8;  12'h11C: begin idx = 8; hi = 1; end
                default: idx = -1;
            endcase
        end else if (sz == 8) begin
            wide = 1;
            case (ofs)
                12'h008: idx = 2;  12'h010: idx = 3;  12'h018: idx = 4;
                12'h108: idx = 6;  12'h110: idx = 7;  12'h118: idx = 8;
                default: idx = -1;
            endcase
        end
    endfunction

    task automatic acc(input string tag, input bit we, input int ch,
                       input logic [11:0] ofs, input logic [3:0] sz, input logic [63:0] wd);
        int idx; bit hi, wide, ok;
        logic [63:0] exp_rd, cur;
        mdl_dec(ofs, sz, idx, hi, wide);
        ok = (idx >= 0) && (ch < NCH);
        exp_rd = 64'h0;
        if (ok) begin
            cur = mdl[ch][idx];
            exp_rd = wide ? cur : (hi ? {32'h0, cur[63:32]} : {32'h0, cur[31:0]});
        end
        req_valid = 1'b1; req_write = we;
        req_addr = {ch[3:0], ofs}; req_size = sz; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check({tag, " err"}, {63'h0, err}, {63'h0, !ok});
        if (!we) begin
            check({tag, " rsp_valid"}, {63'h0, rsp_valid}, 64'h1);
            check({tag, " rdata"}, rsp_rdata, exp_rd);
        end else if (ok && idx < 5) begin
            if (idx < 2)   mdl[ch][idx] = {32'h0, wd[31:0]};
            else if (wide) mdl[ch][idx] = wd;
            else if (hi)   mdl[ch][idx] = {wd[31:0], mdl[ch][idx][31:0]};
            else           mdl[ch][idx] = {mdl[ch][idx][63:32], wd[31:0]};
        end
    endtask

    task automatic pulse_start(input logic [NCH-1:0] m);
        start = m;
        @(posedge clk); @(negedge clk);
        start = '0;
        for (int c = 0; c < NCH; c++)
            if (m[c]) for (int k = 0; k < 4; k++) mdl[c][5+k] = mdl[c][1+k];
    endtask

    task automatic dump_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            acc(tag, 0, c, 12'h000, 4, 0);  acc(tag, 0, c, 12'h004, 4, 0);
            acc(tag, 0, c, 12'h008, 8, 0);  acc(tag, 0, c, 12'h010, 8, 0);
            acc(tag, 0, c, 12'h018, 8, 0);  acc(tag, 0, c, 12'h104, 4, 0);
            acc(tag, 0, c, 12'h108, 8, 0);  acc(tag, 0, c, 12'h110, 8, 0);
            acc(tag, 0, c, 12'h118, 8, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] ofs_list [16];
        logic [3:0]  bad_sz   [4];
        int seed;
        ofs_list = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
                     12'h104, 12'h108, 12'h10C, 12'h110, 12'h114, 12'h118, 12'h11C, 12'h100};
        bad_sz = '{4'd0, 4'd1, 4'd2, 4'd16 - 4'd1};
        for (int c = 0; c < NCH; c++) for (int k = 0; k < 9; k++) mdl[c][k] = 64'h0;
        seed = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        check("R1 rsp_valid at reset", {63'h0, rsp_valid}, 64'h0);
        check("R1 err at reset", {63'h0, err}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        dump_all("R1 reset value");

        // R6: full 64-bit write and read
        acc("R6 wide wr", 1, 1, 12'h010, 8, 64'h1122_3344_5566_7788);
        acc("R6 wide rd", 0, 1, 12'h010, 8, 0);
        // R5: halves are independent; upper wdata ignored for narrow writes
        acc("R5 hi wr", 1, 1, 12'h014, 4, 64'hdead_beef_aaaa_0001);
        acc("R5 lo rd", 0, 1, 12'h010, 4, 0);
        acc("R5 hi rd", 0, 1, 12'h014, 4, 0);
        acc("R5 lo wr", 1, 1, 12'h010, 4, 64'hffff_ffff_0bad_cafe);
        acc("R5 wide rd", 0, 1, 12'h010, 8, 0);
        // R2: other channels untouched
        acc("R2 ch0 rd", 0, 0, 12'h010, 8, 0);
        acc("R2 ch2 rd", 0, 2, 12'h010, 8, 0);
        // R7: exec writes dropped silently
        acc("R7 xdst wr", 1, 1, 12'h110, 8, 64'h1234);
        acc("R7 xdst hi wr", 1, 1, 12'h114, 4, 64'h99);
        acc("R7 xcfg wr", 1, 1, 12'h104, 4, 64'h77);
        acc("R7 xdst rd", 0, 1, 12'h110, 8, 0);
        acc("R7 xcfg rd", 0, 1, 12'h104, 4, 0);
        // R8: 32-bit only words and unmapped offsets
        acc("R8 ctrl wr", 1, 1, 12'h000, 4, 64'h5a5a_0000_0000_00c3);
        acc("R8 ctrl wide wr", 1, 1, 12'h000, 8, 64'hffff);
        acc("R8 ctrl wide rd", 0, 1, 12'h000, 8, 0);
        acc("R8 ncfg wide rd", 0, 1, 12'h004, 8, 0);
        acc("R8 ctrl rd", 0, 1, 12'h000, 4, 0);
        acc("R8 unmapped wr", 1, 1, 12'h020, 4, 64'h1);
        acc("R8 wide at hi half", 0, 1, 12'h014, 8, 0);
        // R3: channel beyond count
        acc("R3 bad ch wr", 1, 5, 12'h010, 8, 64'hcccc);
        acc("R3 bad ch rd", 0, 5, 12'h010, 8, 0);
        acc("R3 bad ch 15 rd", 0, 15, 12'h000, 4, 0);
        // R4: illegal sizes
        acc("R4 size2 wr", 1, 1, 12'h010, 2, 64'h7);
        acc("R4 size1 rd", 0, 1, 12'h010, 1, 0);
        acc("R4 size0 rd", 0, 1, 12'h000, 0, 0);
        acc("R4 after rd", 0, 1, 12'h010, 8, 0);
        // R9: start copies next descriptor
        acc("R9 ncfg wr", 1, 1, 12'h004, 4, 64'h0000_0000_0000_00f1);
        acc("R9 nbytes wr", 1, 1, 12'h008, 8, 64'h0000_0001_0000_0400);
        pulse_start(4'b0010);
        acc("R9 xcfg rd", 0, 1, 12'h104, 4, 0);
        acc("R9 xbytes rd", 0, 1, 12'h108, 8, 0);
        acc("R9 xdst hi rd", 0, 1, 12'h114, 4, 0);
        acc("R9 ch0 exec rd", 0, 0, 12'h108, 8, 0);
        // R11: strobe is one cycle only
        acc("R11 bad", 0, 1, 12'h300, 4, 0);
        @(negedge clk);
        check("R11 err drops", {63'h0, err}, 64'h0);
        check("R10 valid drops", {63'h0, rsp_valid}, 64'h0);

        // random phase
        for (int n = 0; n < 1500; n++) begin
            int ch, r;
            logic [11:0] o;
            logic [3:0] s;
            ch = $urandom % 6;
            r = $urandom % 10;
            o = ($urandom % 8 == 0) ? 12'(($urandom % 1024) * 4) : ofs_list[$urandom % 16];
            s = (r < 4) ? 4'd4 : (r < 8) ? 4'd8 : bad_sz[$urandom % 4];
            if ($urandom % 12 == 0) pulse_start(NCH'($urandom));
            acc("R2 random", ($urandom % 2) == 1, ch, o, s, {$urandom, $urandom});
        end
        dump_all("R2 final sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule